// File: doc/BRIEF.md
# Multi-Core IRQ/FIQ Interrupt Router

This block sits between the interrupt sources of a four-core processor cluster and the cores' two interrupt inputs, the normal-priority IRQ and the fast FIQ. Each core brings four level-sensitive timer requests and four mailbox-pending indications. An upstream interrupt controller supplies one IRQ line and one FIQ line. A local-timer request arrives together with its own routing field. The block decides, for every core, which of these sources raise its IRQ, which raise its FIQ and which are masked.

Each per-core timer or mailbox source has a pair of enable bits in a control register: one steers it to IRQ, the other steers it to FIQ. The FIQ bit wins when both are set. The upstream IRQ and FIQ lines each go to one core selected by a routing register. The local timer goes to the IRQ or FIQ of the core named in its routing input. The per-core pending-source words hold one bit per source at fixed positions. They are recomputed combinationally every cycle, so nothing is latched. Software reads them through a small 32-bit register port, and a core's output is high while its word is nonzero.

Top module: `core_irq_router`

## Requirements
- R1: After reset every routing and control register reads zero, and timer and mailbox sources are masked: with those inputs high and the other inputs low, all IRQ and FIQ outputs are low.
- R2: Timer source s (0..3) of core c is controlled by the timer control register at byte offset 0x40+4*c. Bit s enables IRQ delivery and bit s+4 enables FIQ delivery. A delivered source sets bit s of the core's IRQ or FIQ pending word. When neither bit is set, the source sets no bit.
- R3: When both enable bits of a source are set, the source appears only in the FIQ pending word and never in the IRQ pending word.
- R4: Mailbox j (0..3) of core c is steered by the mailbox control register at 0x50+4*c with the same bit pairing (bit j for IRQ, bit j+4 for FIQ) and appears at pending bit 4+j.
- R5: The upstream routing register at 0x0C holds the core that takes the upstream IRQ in bits 1:0 and the core that takes the upstream FIQ in bits 3:2. It reads back packed the same way with all other bits zero. A routed upstream line sets pending bit 8 of the selected core only.
- R6: When the local-timer request is high, the local-timer routing input steers it. Routing bit 2 selects FIQ when 1 and IRQ when 0, and bits 1:0 select the core. The request sets pending bit 11 of that core's word.
- R7: A core's IRQ output is high exactly when its IRQ pending word is nonzero, and its FIQ output is high exactly when its FIQ pending word is nonzero.
- R8: The IRQ pending word of core c reads at 0x60+4*c and the FIQ pending word reads at 0x70+4*c. Bits 9, 10 and 12 to 31 always read zero.
- R9: A write to a timer or mailbox control register stores only the low 8 bits, and a read returns them zero-extended.
- R10: A read of any unmapped or misaligned offset returns zero. A write there, or to a pending-word offset, changes no register.
- R11: Pending words and outputs follow the input levels in the same cycle. A source that deasserts is removed at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| tmr_lvl_i | input | NUM_CORES*4 | Timer request levels, core c source s at bit 4*c+s |
| mbx_lvl_i | input | NUM_CORES*4 | Mailbox pending levels, core c mailbox j at bit 4*c+j |
| up_irq_i | input | 1 | Upstream controller IRQ level |
| up_fiq_i | input | 1 | Upstream controller FIQ level |
| lt_req_i | input | 1 | Local-timer interrupt request level |
| lt_route_i | input | 3 | Local-timer routing: bit 2 FIQ select, bits 1:0 core |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| irq_o | output | NUM_CORES | Per-core IRQ line |
| fiq_o | output | NUM_CORES | Per-core FIQ line |

## Verification
The bench goes after the case where both enable bits are set. A design that lets IRQ win, or that delivers to both lines, shows the same source bit in both words. It also sends the upstream lines to two different cores at once, which catches a design that swaps the two routing fields or broadcasts bit 8. It deasserts a source and samples before the next clock edge, which exposes any latching of pending bits. Writes to unmapped, misaligned and pending-word offsets are followed by readback of every control register, so a decoder that aliases offsets is caught by a corrupted register.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int CTL_W     = 8;
  localparam int SRC_N     = 4;   // timer sources and mailboxes per core
  localparam int CORE_W    = 2;

  // pending-word bit positions
  localparam int POS_TMR   = 0;
  localparam int POS_MBX   = 4;
  localparam int POS_UP    = 8;
  localparam int POS_LT    = 11;

  // register offsets
  localparam logic [ADDR_W-1:0] OFF_ROUTE = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_TMR   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_MBX   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_IRQW  = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_FIQW  = 8'h70;

  typedef struct packed {
    logic [CORE_W-1:0] fiq_core;
    logic [CORE_W-1:0] irq_core;
  } up_route_t;

  // returns {to_fiq, to_irq}; FIQ enable dominates
  function automatic logic [1:0] pair_steer(input logic irq_en,
                                            input logic fiq_en,
                                            input logic lvl);
    pair_steer = {lvl & fiq_en, lvl & irq_en & ~fiq_en};
  endfunction
endpackage

// File: rtl/irq_ctl_regs.sv
`timescale 1ns/1ps
module irq_ctl_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we_i,
  input  logic [ADDR_W-1:0]               reg_addr_i,
  input  logic [DATA_W-1:0]               reg_wdata_i,
  output up_route_t                       route_o,
  output logic [NUM_CORES-1:0][CTL_W-1:0] tmr_ctl_o,
  output logic [NUM_CORES-1:0][CTL_W-1:0] mbx_ctl_o
);
  up_route_t                       route_q, route_d;
  logic                            route_en;
  logic [NUM_CORES-1:0][CTL_W-1:0] tmr_q, tmr_d, mbx_q, mbx_d;
  logic [NUM_CORES-1:0]            tmr_en, mbx_en;

  // next-state and clock enables
  always_comb begin
    route_en = reg_we_i && (reg_addr_i == OFF_ROUTE);
    route_d  = up_route_t'(reg_wdata_i[2*CORE_W-1:0]);
    for (int c = 0; c < NUM_CORES; c++) begin
      tmr_en[c] = reg_we_i && (reg_addr_i == OFF_TMR + ADDR_W'(4*c));
      mbx_en[c] = reg_we_i && (reg_addr_i == OFF_MBX + ADDR_W'(4*c));
      tmr_d[c]  = reg_wdata_i[CTL_W-1:0];
      mbx_d[c]  = reg_wdata_i[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      tmr_q   <= '0;
      mbx_q   <= '0;
    end else begin
      if (route_en) route_q <= route_d;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (tmr_en[c]) tmr_q[c] <= tmr_d[c];
        if (mbx_en[c]) mbx_q[c] <= mbx_d[c];
      end
    end
  end

  assign route_o   = route_q;
  assign tmr_ctl_o = tmr_q;
  assign mbx_ctl_o = mbx_q;

  // R9: a write to core 0 timer control keeps the low byte of the data
  a_r9_ctl_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == OFF_TMR) |=> (tmr_q[0] == $past(reg_wdata_i[CTL_W-1:0])));

  // R10: misaligned writes touch nothing
  a_r10_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i[1:0] != 2'b00) |=>
      ($stable(route_q) && $stable(tmr_q) && $stable(mbx_q)));
endmodule

// File: rtl/irq_core_steer.sv
`timescale 1ns/1ps
module irq_core_steer
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  tmr_lvl_i,
  input  logic [SRC_N-1:0]  mbx_lvl_i,
  input  logic [CTL_W-1:0]  tmr_ctl_i,
  input  logic [CTL_W-1:0]  mbx_ctl_i,
  input  logic              up_irq_i,
  input  logic              up_fiq_i,
  input  logic              lt_irq_i,
  input  logic              lt_fiq_i,
  output logic [DATA_W-1:0] irq_word_o,
  output logic [DATA_W-1:0] fiq_word_o
);
  logic [1:0] tmr_sel [SRC_N];
  logic [1:0] mbx_sel [SRC_N];

  always_comb begin
    irq_word_o = '0;
    fiq_word_o = '0;
    for (int s = 0; s < SRC_N; s++) begin
      tmr_sel[s] = pair_steer(tmr_ctl_i[s], tmr_ctl_i[s+SRC_N], tmr_lvl_i[s]);
      mbx_sel[s] = pair_steer(mbx_ctl_i[s], mbx_ctl_i[s+SRC_N], mbx_lvl_i[s]);
      irq_word_o[POS_TMR+s] = tmr_sel[s][0];
      fiq_word_o[POS_TMR+s] = tmr_sel[s][1];
      irq_word_o[POS_MBX+s] = mbx_sel[s][0];
      fiq_word_o[POS_MBX+s] = mbx_sel[s][1];
    end
    irq_word_o[POS_UP] = up_irq_i;
    fiq_word_o[POS_UP] = up_fiq_i;
    irq_word_o[POS_LT] = lt_irq_i;
    fiq_word_o[POS_LT] = lt_fiq_i;
  end

  // R3: a per-core source never shows in both words
  a_r3_fiq_over_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_word_o[POS_MBX+SRC_N-1:POS_TMR] & fiq_word_o[POS_MBX+SRC_N-1:POS_TMR]) == '0);

  for (genvar s = 0; s < SRC_N; s++) begin : g_mask_chk
    // R2: no enable bit, no delivery
    a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_ctl_i[s] && !tmr_ctl_i[s+SRC_N]) |->
        (!irq_word_o[POS_TMR+s] && !fiq_word_o[POS_TMR+s]));
    // R4: same rule for mailboxes
    a_r4_mbx_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!mbx_ctl_i[s] && !mbx_ctl_i[s+SRC_N]) |->
        (!irq_word_o[POS_MBX+s] && !fiq_word_o[POS_MBX+s]));
  end
endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [ADDR_W-1:0]                reg_addr_i,
  input  up_route_t                        route_i,
  input  logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl_i,
  input  logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] irq_word_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] fiq_word_i,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam int PAD_W = DATA_W - CTL_W;

  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == OFF_ROUTE)
      rdata_o = {{(DATA_W-2*CORE_W){1'b0}}, route_i};
    for (int c = 0; c < NUM_CORES; c++) begin
      if (reg_addr_i == OFF_TMR + ADDR_W'(4*c))  rdata_o = {{PAD_W{1'b0}}, tmr_ctl_i[c]};
      if (reg_addr_i == OFF_MBX + ADDR_W'(4*c))  rdata_o = {{PAD_W{1'b0}}, mbx_ctl_i[c]};
      if (reg_addr_i == OFF_IRQW + ADDR_W'(4*c)) rdata_o = irq_word_i[c];
      if (reg_addr_i == OFF_FIQW + ADDR_W'(4*c)) rdata_o = fiq_word_i[c];
    end
  end
endmodule

// File: rtl/core_irq_router.sv
`timescale 1ns/1ps
module core_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*SRC_N-1:0]   tmr_lvl_i,
  input  logic [NUM_CORES*SRC_N-1:0]   mbx_lvl_i,
  input  logic                         up_irq_i,
  input  logic                         up_fiq_i,
  input  logic                         lt_req_i,
  input  logic [CORE_W:0]              lt_route_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic [NUM_CORES-1:0]         irq_o,
  output logic [NUM_CORES-1:0]         fiq_o
);
  up_route_t                        route;
  logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl, mbx_ctl;
  logic [NUM_CORES-1:0][DATA_W-1:0] irq_word, fiq_word;
  logic [NUM_CORES-1:0]             up_irq_hit, up_fiq_hit, lt_irq_hit, lt_fiq_hit;
  logic [NUM_CORES-1:0]             up_bit_seen, lt_bit_irq, lt_bit_fiq;

  irq_ctl_regs #(.NUM_CORES(NUM_CORES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .route_o    (route),
    .tmr_ctl_o  (tmr_ctl),
    .mbx_ctl_o  (mbx_ctl)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign up_irq_hit[c] = up_irq_i && (route.irq_core == CORE_W'(c));
    assign up_fiq_hit[c] = up_fiq_i && (route.fiq_core == CORE_W'(c));
    assign lt_irq_hit[c] = lt_req_i && !lt_route_i[CORE_W] && (lt_route_i[CORE_W-1:0] == CORE_W'(c));
    assign lt_fiq_hit[c] = lt_req_i &&  lt_route_i[CORE_W] && (lt_route_i[CORE_W-1:0] == CORE_W'(c));

    irq_core_steer u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr_lvl_i (tmr_lvl_i[c*SRC_N +: SRC_N]),
      .mbx_lvl_i (mbx_lvl_i[c*SRC_N +: SRC_N]),
      .tmr_ctl_i (tmr_ctl[c]),
      .mbx_ctl_i (mbx_ctl[c]),
      .up_irq_i  (up_irq_hit[c]),
      .up_fiq_i  (up_fiq_hit[c]),
      .lt_irq_i  (lt_irq_hit[c]),
      .lt_fiq_i  (lt_fiq_hit[c]),
      .irq_word_o(irq_word[c]),
      .fiq_word_o(fiq_word[c])
    );

    assign irq_o[c]       = |irq_word[c];
    assign fiq_o[c]       = |fiq_word[c];
    assign up_bit_seen[c] = irq_word[c][POS_UP];
    assign lt_bit_irq[c]  = irq_word[c][POS_LT];
    assign lt_bit_fiq[c]  = fiq_word[c][POS_LT];

    // R8: unused positions of the pending words stay zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_word[c][DATA_W-1:POS_LT+1] == '0) && (irq_word[c][POS_LT-1:POS_UP+1] == '0) &&
      (fiq_word[c][DATA_W-1:POS_LT+1] == '0) && (fiq_word[c][POS_LT-1:POS_UP+1] == '0));
  end

  irq_read_mux #(.NUM_CORES(NUM_CORES)) u_rmux (
    .reg_addr_i(reg_addr_i),
    .route_i   (route),
    .tmr_ctl_i (tmr_ctl),
    .mbx_ctl_i (mbx_ctl),
    .irq_word_i(irq_word),
    .fiq_word_i(fiq_word),
    .rdata_o   (reg_rdata_o)
  );

  // R5: the upstream IRQ reaches at most one core
  a_r5_up_one_core: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_bit_seen));

  // R6: the local timer lands on at most one line of one core
  a_r6_lt_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lt_bit_irq, lt_bit_fiq}));

  // R6: no request, no local-timer bit anywhere
  a_r6_lt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_req_i |-> ($countones({lt_bit_irq, lt_bit_fiq}) == 0));
endmodule

// File: tb/sim_core_irq_router.sv
`timescale 1ns/1ps
module sim_core_irq_router;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tmr_lvl, mbx_lvl;
  logic        up_irq, up_fiq, lt_req;
  logic [2:0]  lt_route;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] sh_tmr [NC];
  logic [7:0] sh_mbx [NC];
  logic [1:0] sh_ri, sh_rf;

  core_irq_router #(.NUM_CORES(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .tmr_lvl_i(tmr_lvl), .mbx_lvl_i(mbx_lvl),
    .up_irq_i(up_irq), .up_fiq_i(up_fiq), .lt_req_i(lt_req), .lt_route_i(lt_route),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // expected pending word from the requirements
  function automatic logic [31:0] model(int c, bit f);
    logic [31:0] w = '0;
    for (int s = 0; s < 4; s++) begin
      if (tmr_lvl[c*4+s])
        w[s] = f ? sh_tmr[c][s+4] : (sh_tmr[c][s] && !sh_tmr[c][s+4]);
      if (mbx_lvl[c*4+s])
        w[4+s] = f ? sh_mbx[c][s+4] : (sh_mbx[c][s] && !sh_mbx[c][s+4]);
    end
    if (!f && up_irq && sh_ri == 2'(c)) w[8] = 1'b1;
    if ( f && up_fiq && sh_rf == 2'(c)) w[8] = 1'b1;
    if (lt_req && lt_route[1:0] == 2'(c) && lt_route[2] == f) w[11] = 1'b1;
    return w;
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 8'h0C) begin sh_ri = d[1:0]; sh_rf = d[3:2]; end
    for (int c = 0; c < NC; c++) begin
      if (a == 8'h40 + 8'(4*c)) sh_tmr[c] = d[7:0];
      if (a == 8'h50 + 8'(4*c)) sh_mbx[c] = d[7:0];
    end
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic check_core(string req, int c);
    logic [31:0] d;
    bus_read(8'h60 + 8'(4*c), d);
    check({req, " irq word"}, d, model(c, 0));
    bus_read(8'h70 + 8'(4*c), d);
    check({req, " fiq word"}, d, model(c, 1));
  endtask

  task automatic check_lines(string req);
    logic [3:0] ei, ef;
    for (int c = 0; c < NC; c++) begin
      ei[c] = model(c, 0) != 0;
      ef[c] = model(c, 1) != 0;
    end
    #0.5;
    check({req, " irq_o"}, 32'(irq_o), 32'(ei));
    check({req, " fiq_o"}, 32'(fiq_o), 32'(ef));
  endtask

  task automatic check_regs(string req);
    logic [31:0] d;
    bus_read(8'h0C, d);
    check({req, " route readback"}, d, {28'd0, sh_rf, sh_ri});
    for (int c = 0; c < NC; c++) begin
      bus_read(8'h40 + 8'(4*c), d);
      check({req, " timer ctl readback"}, d, {24'd0, sh_tmr[c]});
      bus_read(8'h50 + 8'(4*c), d);
      check({req, " mailbox ctl readback"}, d, {24'd0, sh_mbx[c]});
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    tmr_lvl = '1; mbx_lvl = '1; up_irq = 0; up_fiq = 0; lt_req = 0; lt_route = '0;
    for (int c = 0; c < NC; c++) begin sh_tmr[c] = '0; sh_mbx[c] = '0; end
    sh_ri = '0; sh_rf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything masked after reset
    check_lines("R1");
    check_regs("R1");

    // R2: timer source 0 of core 1, IRQ then FIQ then masked
    tmr_lvl = 16'h0010; mbx_lvl = '0;
    bus_write(8'h44, 32'h0000_0001);
    check_core("R2", 1); check_lines("R2");
    bus_write(8'h44, 32'h0000_0010);
    check_core("R2", 1); check_lines("R2");
    bus_write(8'h44, 32'h0000_0000);
    check_core("R2", 1); check_lines("R2");

    // R3: both bits set, FIQ only
    bus_write(8'h44, 32'h0000_0011);
    check_core("R3", 1);
    bus_read(8'h64, d); check("R3 irq word clear", d, 32'h0);
    bus_read(8'h74, d); check("R3 fiq word bit0", d, 32'h1);

    // R4: mailbox 2 of core 3 to IRQ, bit 6
    tmr_lvl = '0; mbx_lvl = 16'h4000;
    bus_write(8'h5C, 32'h0000_0004);
    bus_read(8'h6C, d); check("R4 mailbox bit", d, 32'h40);
    check_lines("R4");

    // R9: only the low byte stored
    bus_write(8'h48, 32'hFFFF_FF5A);
    bus_read(8'h48, d); check("R9 low byte kept", d, 32'h5A);

    // R5: upstream IRQ to core 1, FIQ to core 2
    mbx_lvl = '0;
    bus_write(8'h0C, 32'hFFFF_FFF9);
    bus_read(8'h0C, d); check("R5 route packed", d, 32'h9);
    up_irq = 1; up_fiq = 1;
    bus_read(8'h64, d); check("R5 irq bit8 core1", d, 32'h100);
    bus_read(8'h74, d); check("R5 fiq bit8 core2 absent on core1", d, 32'h1 & model(1,1));
    bus_read(8'h78, d); check("R5 fiq bit8 core2", d, 32'h100);
    bus_read(8'h60, d); check("R5 core0 clear", d, 32'h0);
    check_lines("R7");

    // R6: local timer to FIQ of core 2, then IRQ of core 3
    up_irq = 0; up_fiq = 0; lt_req = 1; lt_route = 3'b110;
    bus_read(8'h78, d); check("R6 lt fiq core2", d, 32'h800);
    lt_route = 3'b011;
    bus_read(8'h6C, d); check("R6 lt irq core3", d, 32'h800);
    check_lines("R6");

    // R11: removal without a clock edge
    lt_req = 0;
    @(negedge clk);
    lt_req = 1;
    #0.5; check("R11 raise same cycle", 32'(irq_o), 32'h8);
    lt_req = 0;
    #0.5; check("R11 drop same cycle", 32'(irq_o), 32'h0);

    // R10: unmapped and pending-word writes ignored
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'h41, 32'hFFFF_FFFF);
    bus_write(8'h60, 32'hFFFF_FFFF);
    bus_write(8'h7C, 32'hFFFF_FFFF);
    check_regs("R10");
    bus_read(8'h20, d); check("R10 unmapped read", d, 32'h0);
    bus_read(8'h42, d); check("R10 misaligned read", d, 32'h0);

    // random mix, R7 and R8 against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tmr_lvl = 16'($urandom); mbx_lvl = 16'($urandom);
      up_irq = 1'($urandom); up_fiq = 1'($urandom);
      lt_req = 1'($urandom); lt_route = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        int k = $urandom_range(0, 3);
        case ($urandom_range(0, 3))
          0: bus_write(8'h0C, $urandom);
          1: bus_write(8'h40 + 8'(4*k), $urandom);
          2: bus_write(8'h50 + 8'(4*k), $urandom);
          default: bus_write(8'(8'h80 + 8'($urandom_range(0, 127))), $urandom);
        endcase
      end
      check_lines("R7");
      check_core("R8", $urandom_range(0, 3));
    end
    check_regs("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule